// File: doc/BRIEF.md
# Serial Code Entry Lock

This block accepts a four-bit access code one bit at a time. A strobe input marks each bit, and a single data input carries the bit's value. Both inputs are brought into the system clock domain through synchronisers, and edge detection turns each strobe pulse into one shift of a small register. A bit counter runs in step with the shifts and tells the block when the code is complete. When the count reaches four, the stored code is compared with a preset code input, and the block raises exactly one of two result outputs: `accept` when the two codes match, or `reject` when they differ.

While entry is still in progress, a blink output follows a slow square wave made inside the block by a clock divider. The blink stops as soon as the last bit is counted. Once entry is complete, further strobes are ignored, and the result holds until an active-low asynchronous clear empties the register and the counter.

The lock is meant to be driven directly by a front panel or a simple controller that presents one bit per strobe pulse.

Top module: `serial_code_lock`

## Requirements
- R1: While `rstN` is low and just after it is released, `accept`, `reject` and the stored code are all zero, and the block is in entry mode with no bits counted.
- R2: Bits are entered most significant first: the first bit entered is compared with `presetCode[3]`, the second with `presetCode[2]`, the third with `presetCode[1]` and the fourth with `presetCode[0]`.
- R3: After the falling edge of the fourth strobe, `accept` is 1 and `reject` is 0 if every stored bit equals its preset bit.
- R4: After the falling edge of the fourth strobe, `reject` is 1 and `accept` is 0 if one or more stored bits differ from the preset. A single differing bit is enough.
- R5: Before the fourth strobe is counted, both `accept` and `reject` stay 0.
- R6: `accept` and `reject` are never 1 at the same time.
- R7: During entry, `blink` follows an internal phase that toggles every `BLINK_HALF` clock cycles. After entry is complete, `blink` stays 0.
- R8: Strobes that arrive after entry is complete do not change the stored code or the count, so the result holds until the next clear.
- R9: Asserting `rstN` in the middle of entry discards the partial code. The next four bits then form a new code on their own.
- R10: Each strobe pulse shifts in exactly one bit, however many clock cycles the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous clear |
| entryStrobe | input | 1 | Bit strobe; a bit is shifted in on its rising edge and counted on its falling edge |
| serialBit | input | 1 | Code bit value, held stable around the strobe |
| presetCode | input | CODE_W | Code to compare against |
| accept | output | 1 | Entry complete and code matches |
| reject | output | 1 | Entry complete and code differs |
| blink | output | 1 | Slow blink while entry is in progress |

## Verification
A wrong bit order or a wrong bit pairing in the shift register shows up as a flipped `accept`/`reject` result. This appears a few cycles after the fourth strobe falls, and only for asymmetric codes, so the bench uses codes such as 1011 and codes that differ in a single bit. A counter that miscounts or fails to saturate shows up as a result that appears after the third strobe, or as a result that changes when extra strobes arrive. A faulty synchroniser or edge detector turns a long strobe into several shifts. This garbles a result that would otherwise be correct by the next completed code. A divider fault shows up as a blink period different from `BLINK_HALF` within the first two toggles.

// File: rtl/lock_pkg.sv
package lock_pkg;

  // Strobes passed from the control path to the datapath.
  typedef struct packed {
    logic shiftEn;     // one-cycle pulse: shift bitValue into the code register
    logic bitValue;    // synchronised serial bit
    logic entryDone;   // all code bits counted
    logic blinkPhase;  // slow square wave from the divider
  } ctrl_t;

endpackage

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int BLINK_HALF  = 25_000_000
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  strobeIn,
  input  logic  dataIn,
  output ctrl_t ctrl
);

  localparam int CNT_W = $clog2(CODE_W + 1);
  localparam int DIV_W = $clog2(BLINK_HALF + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CODE_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BLINK_HALF - 1);

  logic [SYNC_STAGES-1:0] strobeSync;
  logic [SYNC_STAGES-1:0] dataSync;
  logic strobeS, strobeQ, dataS;
  logic strobeRise, strobeFall;
  logic [CNT_W-1:0] bitCount;
  logic entryDone;
  logic [DIV_W-1:0] divCnt;
  logic blinkPhase;

  // Synchroniser chains for strobe and data
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            strobeSync[0] <= 1'b0;
            dataSync[0]   <= 1'b0;
          end else begin
            strobeSync[0] <= strobeIn;
            dataSync[0]   <= dataIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            strobeSync[s] <= 1'b0;
            dataSync[s]   <= 1'b0;
          end else begin
            strobeSync[s] <= strobeSync[s-1];
            dataSync[s]   <= dataSync[s-1];
          end
        end
      end
    end
  endgenerate

  assign strobeS = strobeSync[SYNC_STAGES-1];
  assign dataS   = dataSync[SYNC_STAGES-1];

  // Edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeQ <= 1'b0;
    else       strobeQ <= strobeS;
  end

  assign strobeRise = strobeS & ~strobeQ;
  assign strobeFall = ~strobeS & strobeQ;

  // Bit counter: advances on the falling strobe edge and saturates at CODE_W
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (strobeFall && bitCount != CNT_FULL) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  assign entryDone = (bitCount == CNT_FULL);

  // Blink divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt     <= '0;
      blinkPhase <= 1'b0;
    end else if (divCnt == DIV_LAST) begin
      divCnt     <= '0;
      blinkPhase <= ~blinkPhase;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.shiftEn    = strobeRise & ~entryDone;
    ctrl.bitValue   = dataS;
    ctrl.entryDone  = entryDone;
    ctrl.blinkPhase = blinkPhase;
  end

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_FULL) else $error("bit count above code width"); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (bitCount != $past(bitCount)) |-> (bitCount == $past(bitCount) + 1'b1))
    else $error("bit count jumped"); // R10

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |=> entryDone) else $error("completion dropped without clear"); // R8

  AST_ONE_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> !ctrl.shiftEn) else $error("shift pulse longer than one cycle"); // R10

endmodule

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [CODE_W-1:0] presetCode,
  output logic              accept,
  output logic              reject,
  output logic              blink
);

  logic [CODE_W-1:0] codeReg;
  logic [CODE_W-1:0] bitEq;
  logic match;

  // The first bit entered moves up to the top position as later bits arrive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             codeReg <= '0;
    else if (ctrl.shiftEn) codeReg <= {codeReg[CODE_W-2:0], ctrl.bitValue};
  end

  genvar i;
  generate
    for (i = 0; i < CODE_W; i++) begin : g_cmp
      assign bitEq[i] = ~(codeReg[i] ^ presetCode[i]);
    end
  endgenerate

  assign match  = &bitEq;
  assign accept = ctrl.entryDone & match;
  assign reject = ctrl.entryDone & ~match;
  assign blink  = ~ctrl.entryDone & ctrl.blinkPhase;

  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.entryDone |=> $stable(codeReg)) else $error("code changed after completion"); // R8

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(accept && reject)) else $error("accept and reject together"); // R6

  AST_BLINK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.entryDone |-> !blink) else $error("blink after completion"); // R7

endmodule

// File: rtl/serial_code_lock.sv
module serial_code_lock
  import lock_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int BLINK_HALF  = 25_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              entryStrobe,
  input  logic              serialBit,
  input  logic [CODE_W-1:0] presetCode,
  output logic              accept,
  output logic              reject,
  output logic              blink
);

  ctrl_t ctrlBus;

  lock_ctrl #(
    .CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES), .BLINK_HALF(BLINK_HALF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .strobeIn(entryStrobe), .dataIn(serialBit), .ctrl(ctrlBus)
  );

  lock_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrlBus), .presetCode(presetCode),
    .accept(accept), .reject(reject), .blink(blink)
  );

endmodule

// File: tb/serial_code_lock_tb.sv
`timescale 1ns/1ps
module serial_code_lock_tb;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic entryStrobe = 1'b0;
  logic serialBit = 1'b0;
  logic [3:0] presetCode = 4'b0000;
  logic accept, reject, blink;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  serial_code_lock #(.CODE_W(4), .SYNC_STAGES(2), .BLINK_HALF(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .entryStrobe(entryStrobe), .serialBit(serialBit),
    .presetCode(presetCode), .accept(accept), .reject(reject), .blink(blink)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doClear();
    @(negedge clk);
    rstN = 1'b0;
    entryStrobe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input int hold);
    @(negedge clk);
    serialBit = b;
    entryStrobe = 1'b1;
    repeat (hold) @(negedge clk);
    entryStrobe = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // first bit sent is code[3]
  task automatic sendCode(input logic [3:0] code, input int hold);
    for (int k = 3; k >= 0; k--) sendBit(code[k], hold);
  endtask

  task automatic checkResult(input string req, input bit expAcc);
    check(accept == expAcc, req, accept, expAcc);
    check(reject == !expAcc, req, reject, !expAcc);
  endtask

  task automatic tReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(accept == 0, "R1 accept in clear", accept, 0);
    check(reject == 0, "R1 reject in clear", reject, 0);
    doClear();
    check(accept == 0 && reject == 0, "R1 after release", {accept, reject}, 0);
    // stored code zero: matches an all-zero preset once four zeros complete
  endtask

  task automatic tMatch();
    doClear();
    presetCode = 4'b1011;
    sendBit(1'b1, 4); sendBit(1'b0, 4); sendBit(1'b1, 4);
    check(accept == 0 && reject == 0, "R5 three bits", {accept, reject}, 0);
    sendBit(1'b1, 4);
    checkResult("R3 match 1011", 1'b1);
    check(!(accept && reject), "R6 exclusive", {accept, reject}, 2);
  endtask

  task automatic tOrder();
    doClear();
    presetCode = 4'b1000;   // first bit entered pairs with presetCode[3]
    sendCode(4'b1000, 4);
    checkResult("R2 msb first", 1'b1);
    doClear();
    presetCode = 4'b0001;
    sendBit(1'b1, 4); sendBit(1'b0, 4); sendBit(1'b0, 4); sendBit(1'b0, 4);
    checkResult("R2 reversed order rejects", 1'b0);
  endtask

  task automatic tMismatch();
    doClear();
    presetCode = 4'b0110;
    sendCode(4'b0111, 4);
    checkResult("R4 single-bit mismatch", 1'b0);
  endtask

  task automatic tZeros();
    doClear();
    presetCode = 4'b0000;
    sendCode(4'b0000, 4);
    checkResult("R3 all zero", 1'b1);
  endtask

  task automatic tClearMid();
    doClear();
    presetCode = 4'b0101;
    sendBit(1'b1, 4); sendBit(1'b1, 4);
    doClear();
    check(accept == 0 && reject == 0, "R9 cleared mid entry", {accept, reject}, 0);
    sendCode(4'b0101, 4);
    checkResult("R9 fresh code after clear", 1'b1);
  endtask

  task automatic tExtra();
    doClear();
    presetCode = 4'b1100;
    sendCode(4'b1100, 4);
    checkResult("R8 before extra strobes", 1'b1);
    sendBit(1'b1, 4); sendBit(1'b1, 4); sendBit(1'b0, 4);
    checkResult("R8 after extra strobes", 1'b1);
    check(blink == 0, "R8 blink stays off", blink, 0);
  endtask

  task automatic tLongStrobe();
    doClear();
    presetCode = 4'b1001;
    sendBit(1'b1, 40);
    sendBit(1'b0, 25); sendBit(1'b0, 4);
    check(accept == 0 && reject == 0, "R10 three long strobes", {accept, reject}, 0);
    sendBit(1'b1, 30);
    checkResult("R10 long strobes", 1'b1);
  endtask

  task automatic tBlink();
    int n;
    logic prev;
    bit seenEdge;
    doClear();
    prev = blink;
    seenEdge = 0;
    for (int c = 0; c < 4 * HALF && !seenEdge; c++) begin
      @(negedge clk);
      if (blink != prev) seenEdge = 1;
      prev = blink;
    end
    check(seenEdge, "R7 blink toggles in entry", seenEdge, 1);
    n = 0;
    for (int c = 0; c < 4 * HALF; c++) begin
      @(negedge clk);
      n++;
      if (blink != prev) break;
    end
    check(n == HALF, "R7 blink half period", n, HALF);
    presetCode = 4'b0011;
    sendCode(4'b0010, 4);
    n = 0;
    for (int c = 0; c < 3 * HALF; c++) begin
      @(negedge clk);
      if (blink) n++;
    end
    check(n == 0, "R7 blink off after completion", n, 0);
    checkResult("R4 after blink test", 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tReset();
    tMatch();
    tOrder();
    tMismatch();
    tZeros();
    tClearMid();
    tExtra();
    tLongStrobe();
    tBlink();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule